// File: doc/BRIEF.md
# Instruction decode stage with in-stage branch resolution

This block is the second stage of a five-stage in-order pipeline that runs a reduced instruction set of six operations: add-unsigned, subtract-unsigned, load word, store word, branch-if-not-equal and a custom halt. Each cycle it takes the fetched instruction, its PC+4 and the stage's bubble bit. It reads two operands from the register file it owns, decodes the control bits and loads the decode/execute pipeline register. That register holds the operands, the source and destination addresses, the sign-extended immediate and the control flags.

The not-equal branch is settled here rather than in execute. The two operands are compared and the target is formed in the same cycle, and a taken flag with its target address goes straight back to fetch. A halt opcode is also flagged to fetch in the same cycle. The register file is written by the writeback stage through a dedicated write port. A write in a given cycle is visible to a read of the same register in that cycle.

Top module: `idu_stage`

## Requirements
- R1: While rst_n is low, and until the first decoded instruction is clocked in, x_bubble is 1 and x_reg_we, x_mem_rd and x_mem_wr are 0.
- R2: An instruction with opcode bits 31:26 = 0x00 and function bits 5:0 = 0x21 (add) or 0x23 (subtract) loads, on the next rising edge, x_reg_we=1, x_is_itype=0, x_bubble=0, x_dest = bits 15:11, and x_alu_add=1 for 0x21 or x_alu_add=0 for 0x23.
- R3: Opcode 0x23 (load) loads x_mem_rd=1, x_mem_wr=0, x_reg_we=1, x_alu_add=1, x_is_itype=1, x_dest = bits 20:16, and x_imm = bits 15:0 sign-extended to 32 bits.
- R4: Opcode 0x2B (store) loads x_mem_wr=1, x_mem_rd=0, x_reg_we=0, x_alu_add=1 and x_is_itype=1, and x_rdata2 carries the value of the register named in bits 20:16.
- R5: For every instruction, x_rs = bits 25:21 and x_rt = bits 20:16, and x_rdata1 and x_rdata2 hold the register-file contents at those addresses.
- R6: A register-file write (wb_we=1) lands on the rising edge and is read back afterwards. Register 0 always reads as 0, and writes to it are dropped.
- R7: When wb_we=1 and wb_addr (nonzero) matches a read address in the same cycle, that read returns wb_data.
- R8: Opcode 0x05 (branch-if-not-equal) raises br_taken in the same cycle exactly when the two read values differ. br_target = in_pc4 + (sign-extended bits 15:0 shifted left by 2), negative offsets included. The instruction loads no register or memory flag.
- R9: Opcode 0x3F (halt) raises id_halt in the same cycle. On the next edge it loads x_bubble=1 with all register and memory flags at 0.
- R10: When in_bubble=1, br_taken and id_halt are 0. On the next edge x_bubble=1 and x_reg_we, x_mem_rd and x_mem_wr are 0, whatever the instruction bits are.
- R11: An unrecognised opcode, or opcode 0x00 with an unrecognised function code, loads x_bubble=1 with all register and memory flags at 0.
- R12: x_mem_rd and x_mem_wr are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_instr | input | 32 | Instruction from the fetch/decode register |
| in_pc4 | input | 32 | PC+4 of that instruction |
| in_bubble | input | 1 | Bubble bit of this stage; 1 means no operation |
| wb_we | input | 1 | Register-file write enable from writeback |
| wb_addr | input | 5 | Register-file write address |
| wb_data | input | 32 | Register-file write data |
| br_taken | output | 1 | Branch taken, to fetch (combinational) |
| br_target | output | 32 | Branch target address, to fetch (combinational) |
| id_halt | output | 1 | Halt decoded this cycle, to fetch (combinational) |
| x_bubble | output | 1 | Decode/execute register: bubble bit |
| x_rdata1 | output | 32 | Decode/execute register: first operand |
| x_rdata2 | output | 32 | Decode/execute register: second operand |
| x_rs | output | 5 | Decode/execute register: first source address |
| x_rt | output | 5 | Decode/execute register: second source address |
| x_dest | output | 5 | Decode/execute register: destination address |
| x_imm | output | 32 | Decode/execute register: sign-extended immediate |
| x_alu_add | output | 1 | Decode/execute register: 1 add, 0 subtract |
| x_is_itype | output | 1 | Decode/execute register: immediate-format instruction |
| x_reg_we | output | 1 | Decode/execute register: register write enable |
| x_mem_rd | output | 1 | Decode/execute register: memory read |
| x_mem_wr | output | 1 | Decode/execute register: memory write |

## Verification
The decoder is driven with every legal opcode and with illegal opcode and function codes. Each produces its own combination of flags, so a swapped or merged decode case shows up at once. The branch is tried with equal and unequal operands and with a negative offset, which separates the compare sense and the sign extension of the target. The same instructions are repeated with the bubble bit set, to tell forced-off flags from decoded ones. Register reads are checked after writes to register 0, after writes to an ordinary register, and during a write to the same register in the same cycle, which separates the zero register, storage and write-through paths.

// File: rtl/idu_pkg.sv
// Shared encodings and the decoded-control record for the decode stage.
// Assumes the fixed 32-bit instruction format with 5-bit register fields.
package idu_pkg;
    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_HALT  = 6'h3F;
    localparam logic [5:0] FN_ADDU  = 6'h21;
    localparam logic [5:0] FN_SUBU  = 6'h23;

    typedef struct packed {
        logic valid;     // recognised and not a bubble
        logic alu_add;
        logic is_itype;
        logic reg_we;
        logic mem_rd;
        logic mem_wr;
        logic is_bne;
        logic is_halt;
    } ctrl_t;
endpackage

// File: rtl/idu_regfile.sv
// Register file: NREG words of XLEN bits, two read ports, one write port.
// Register 0 is hardwired to zero. A same-cycle write to a read address is
// passed straight through to the read data.
module idu_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);
    logic [XLEN-1:0] file_q [NREG];

    assign file_q[0] = '0;

    genvar g;
    generate
        for (g = 1; g < NREG; g++) begin : g_reg
            logic [XLEN-1:0] q;
            // Holds register g; loads on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && waddr == AW'(g))
                    q <= wdata;
            end
            assign file_q[g] = q;
        end
    endgenerate

    // Read port 1 with write-through from the writeback port.
    always_comb begin
        if (we && waddr != '0 && waddr == ra1)
            rd1 = wdata;
        else
            rd1 = file_q[ra1];
    end

    // Read port 2 with write-through from the writeback port.
    always_comb begin
        if (we && waddr != '0 && waddr == ra2)
            rd2 = wdata;
        else
            rd2 = file_q[ra2];
    end
endmodule

// File: rtl/idu_ctrl.sv
// Control decoder: maps opcode/function to the control record and picks the
// destination register. Unknown codes and bubbles give an all-zero record.
module idu_ctrl
    import idu_pkg::*;
(
    input  logic [31:0]    instr,
    input  logic           bubble,
    output ctrl_t          ctrl,
    output logic [RAW-1:0] dest
);
    logic [5:0] opc;
    logic [5:0] fn;
    logic       unused_shamt;

    assign opc          = instr[31:26];
    assign fn           = instr[5:0];
    assign unused_shamt = ^instr[10:6];

    // Decodes the operation class into control flags.
    always_comb begin
        ctrl = '0;
        unique case (opc)
            OP_RTYPE: begin
                if (fn == FN_ADDU || fn == FN_SUBU) begin
                    ctrl.valid   = 1'b1;
                    ctrl.reg_we  = 1'b1;
                    ctrl.alu_add = (fn == FN_ADDU);
                end
            end
            OP_LOAD: begin
                ctrl.valid    = 1'b1;
                ctrl.alu_add  = 1'b1;
                ctrl.is_itype = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.mem_rd   = 1'b1;
            end
            OP_STORE: begin
                ctrl.valid    = 1'b1;
                ctrl.alu_add  = 1'b1;
                ctrl.is_itype = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            OP_BNE: begin
                ctrl.valid    = 1'b1;
                ctrl.is_itype = 1'b1;
                ctrl.is_bne   = 1'b1;
            end
            OP_HALT: begin
                ctrl.is_halt = 1'b1;
            end
            default: ctrl = '0;
        endcase
        if (bubble)
            ctrl = '0;
    end

    // Picks the destination field: rd for register format, rt for load.
    always_comb begin
        if (opc == OP_RTYPE)
            dest = instr[15:11];
        else if (opc == OP_LOAD)
            dest = instr[20:16];
        else
            dest = '0;
    end
endmodule

// File: rtl/idu_branch.sv
// Branch resolver: not-equal compare of the two operands and target
// formation from PC+4 and the word-scaled immediate. Assumes the operands
// need no forwarding.
module idu_branch #(
    parameter int XLEN = 32
) (
    input  logic            is_bne,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] pc4,
    input  logic [XLEN-1:0] imm_sx,
    output logic            taken,
    output logic [XLEN-1:0] target
);
    // Compares the operands and forms the target address.
    always_comb begin
        taken  = is_bne && (op_a != op_b);
        target = pc4 + {imm_sx[XLEN-3:0], 2'b00};
    end
endmodule

// File: rtl/idu_stage.sv
// Decode stage top: register file, control decoder, branch resolver and the
// decode/execute pipeline register. Branch and halt outputs go to fetch in
// the same cycle; everything else appears one clock later.
module idu_stage
    import idu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     in_instr,
    input  logic [31:0]     in_pc4,
    input  logic            in_bubble,
    input  logic            wb_we,
    input  logic [4:0]      wb_addr,
    input  logic [31:0]     wb_data,
    output logic            br_taken,
    output logic [31:0]     br_target,
    output logic            id_halt,
    output logic            x_bubble,
    output logic [31:0]     x_rdata1,
    output logic [31:0]     x_rdata2,
    output logic [4:0]      x_rs,
    output logic [4:0]      x_rt,
    output logic [4:0]      x_dest,
    output logic [31:0]     x_imm,
    output logic            x_alu_add,
    output logic            x_is_itype,
    output logic            x_reg_we,
    output logic            x_mem_rd,
    output logic            x_mem_wr
);
    logic [RAW-1:0]  rs_a;
    logic [RAW-1:0]  rt_a;
    logic [XLEN-1:0] rdata1;
    logic [XLEN-1:0] rdata2;
    logic [XLEN-1:0] imm_sx;
    logic [RAW-1:0]  dest;
    ctrl_t           ctrl;

    assign rs_a   = in_instr[25:21];
    assign rt_a   = in_instr[20:16];
    assign imm_sx = {{(XLEN-16){in_instr[15]}}, in_instr[15:0]};

    idu_regfile #(.XLEN(XLEN), .NREG(1 << RAW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra1   (rs_a),
        .ra2   (rt_a),
        .rd1   (rdata1),
        .rd2   (rdata2)
    );

    idu_ctrl u_ctrl (
        .instr  (in_instr),
        .bubble (in_bubble),
        .ctrl   (ctrl),
        .dest   (dest)
    );

    idu_branch #(.XLEN(XLEN)) u_br (
        .is_bne (ctrl.is_bne),
        .op_a   (rdata1),
        .op_b   (rdata2),
        .pc4    (in_pc4),
        .imm_sx (imm_sx),
        .taken  (br_taken),
        .target (br_target)
    );

    assign id_halt = ctrl.is_halt;

    // Loads the decode/execute register; reset leaves it holding a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_bubble   <= 1'b1;
            x_rdata1   <= '0;
            x_rdata2   <= '0;
            x_rs       <= '0;
            x_rt       <= '0;
            x_dest     <= '0;
            x_imm      <= '0;
            x_alu_add  <= 1'b0;
            x_is_itype <= 1'b0;
            x_reg_we   <= 1'b0;
            x_mem_rd   <= 1'b0;
            x_mem_wr   <= 1'b0;
        end else begin
            x_bubble   <= !ctrl.valid;
            x_rdata1   <= rdata1;
            x_rdata2   <= rdata2;
            x_rs       <= rs_a;
            x_rt       <= rt_a;
            x_dest     <= dest;
            x_imm      <= imm_sx;
            x_alu_add  <= ctrl.alu_add;
            x_is_itype <= ctrl.is_itype;
            x_reg_we   <= ctrl.reg_we;
            x_mem_rd   <= ctrl.mem_rd;
            x_mem_wr   <= ctrl.mem_wr;
        end
    end
endmodule

// File: rtl/idu_stage_chk.sv
// Checker for the decode stage, bound to every idu_stage instance.
module idu_stage_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] in_instr,
    input logic        in_bubble,
    input logic        br_taken,
    input logic        id_halt,
    input logic [31:0] rdata1,
    input logic [31:0] rdata2,
    input logic        x_bubble,
    input logic        x_reg_we,
    input logic        x_mem_rd,
    input logic        x_mem_wr,
    input logic        x_is_itype
);
    // A bubble input leaves no side effect in the next cycle.
    assert_bubble_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_bubble |=> (x_bubble && !x_reg_we && !x_mem_rd && !x_mem_wr));

    // Nothing reaches fetch from a bubble.
    assert_bubble_no_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_bubble |-> (!br_taken && !id_halt));

    // Taken only for a branch opcode whose register reads differ.
    assert_taken_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (in_instr[31:26] == 6'h05 && rdata1 != rdata2));

    // Halt clocks a bubble into the next stage.
    assert_halt_bubbles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        id_halt |=> (x_bubble && !x_reg_we && !x_mem_rd && !x_mem_wr));

    // Memory read and write flags are exclusive.
    assert_mem_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_mem_rd && x_mem_wr));

    // A memory access is always an immediate-format operation.
    assert_mem_itype_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_mem_rd || x_mem_wr) |-> x_is_itype);

    // Register 0 reads as zero.
    assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_instr[25:21] == 5'd0) |-> (rdata1 == 32'd0));
endmodule

bind idu_stage idu_stage_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_instr   (in_instr),
    .in_bubble  (in_bubble),
    .br_taken   (br_taken),
    .id_halt    (id_halt),
    .rdata1     (rdata1),
    .rdata2     (rdata2),
    .x_bubble   (x_bubble),
    .x_reg_we   (x_reg_we),
    .x_mem_rd   (x_mem_rd),
    .x_mem_wr   (x_mem_wr),
    .x_is_itype (x_is_itype)
);

// File: tb/tb_idu_stage.sv
// Directed bench for the decode stage: one task per scenario.
module tb_idu_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_pc4 = '0;
    logic        in_bubble = 1'b1;
    logic        wb_we = 1'b0;
    logic [4:0]  wb_addr = '0;
    logic [31:0] wb_data = '0;
    logic        br_taken, id_halt, x_bubble, x_alu_add, x_is_itype;
    logic        x_reg_we, x_mem_rd, x_mem_wr;
    logic [31:0] br_target, x_rdata1, x_rdata2, x_imm;
    logic [4:0]  x_rs, x_rt, x_dest;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    idu_stage dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rtype(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // Writes one register through the writeback port.
    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        in_bubble = 1'b1;
        wb_we = 1'b1; wb_addr = a; wb_data = d;
        @(negedge clk);
        wb_we = 1'b0;
    endtask

    // Presents an instruction at a falling edge and waits for settle.
    task automatic present(input logic [31:0] ins, input logic bub, input logic [31:0] pc4);
        @(negedge clk);
        in_instr = ins; in_bubble = bub; in_pc4 = pc4;
        #1;
    endtask

    // Moves past the next rising edge so the pipeline register is visible.
    task automatic clock_in();
        @(posedge clk);
        #1;
        wb_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 x_bubble", 32'(x_bubble), 1);
        chk("R1 x_reg_we", 32'(x_reg_we), 0);
        chk("R1 x_mem_rd", 32'(x_mem_rd), 0);
        chk("R1 x_mem_wr", 32'(x_mem_wr), 0);
    endtask

    task automatic t_rtype();
        present(rtype(5'd3, 5'd4, 5'd9, 6'h21), 1'b0, 32'h40);
        clock_in();
        chk("R2 addu alu_add", 32'(x_alu_add), 1);
        chk("R2 addu reg_we", 32'(x_reg_we), 1);
        chk("R2 addu dest", 32'(x_dest), 9);
        chk("R2 addu itype", 32'(x_is_itype), 0);
        chk("R2 addu bubble", 32'(x_bubble), 0);
        chk("R5 rs", 32'(x_rs), 3);
        chk("R5 rt", 32'(x_rt), 4);
        chk("R5 rdata1", x_rdata1, 32'd7);
        chk("R5 rdata2", x_rdata2, 32'hFFFF_FFF0);
        present(rtype(5'd1, 5'd2, 5'd12, 6'h23), 1'b0, 32'h44);
        clock_in();
        chk("R2 subu alu_add", 32'(x_alu_add), 0);
        chk("R2 subu reg_we", 32'(x_reg_we), 1);
        chk("R2 subu dest", 32'(x_dest), 12);
    endtask

    task automatic t_load();
        present(itype(6'h23, 5'd5, 5'd6, 16'hFFFC), 1'b0, 32'h48);
        clock_in();
        chk("R3 mem_rd", 32'(x_mem_rd), 1);
        chk("R3 mem_wr", 32'(x_mem_wr), 0);
        chk("R3 reg_we", 32'(x_reg_we), 1);
        chk("R3 alu_add", 32'(x_alu_add), 1);
        chk("R3 itype", 32'(x_is_itype), 1);
        chk("R3 dest", 32'(x_dest), 6);
        chk("R3 imm", x_imm, 32'hFFFF_FFFC);
        chk("R5 load rdata1", x_rdata1, 32'h1234);
    endtask

    task automatic t_store();
        present(itype(6'h2B, 5'd1, 5'd3, 16'h0008), 1'b0, 32'h4C);
        clock_in();
        chk("R4 mem_wr", 32'(x_mem_wr), 1);
        chk("R4 mem_rd", 32'(x_mem_rd), 0);
        chk("R4 reg_we", 32'(x_reg_we), 0);
        chk("R4 alu_add", 32'(x_alu_add), 1);
        chk("R4 itype", 32'(x_is_itype), 1);
        chk("R4 store data", x_rdata2, 32'd7);
        chk("R3 positive imm", x_imm, 32'h8);
    endtask

    task automatic t_branch();
        present(itype(6'h05, 5'd1, 5'd3, 16'hFFFE), 1'b0, 32'h100);
        chk("R8 taken differ", 32'(br_taken), 1);
        chk("R8 target back", br_target, 32'hF8);
        clock_in();
        chk("R8 no reg_we", 32'(x_reg_we), 0);
        chk("R8 no mem", 32'({x_mem_rd, x_mem_wr}), 0);
        present(itype(6'h05, 5'd1, 5'd2, 16'h0010), 1'b0, 32'h200);
        chk("R8 not taken equal", 32'(br_taken), 0);
        chk("R8 target fwd", br_target, 32'h240);
        clock_in();
    endtask

    task automatic t_halt();
        present({6'h3F, 26'h155_5555}, 1'b0, 32'h300);
        chk("R9 id_halt", 32'(id_halt), 1);
        chk("R9 no taken", 32'(br_taken), 0);
        clock_in();
        chk("R9 x_bubble", 32'(x_bubble), 1);
        chk("R9 flags", 32'({x_reg_we, x_mem_rd, x_mem_wr}), 0);
    endtask

    task automatic t_bubble();
        present(itype(6'h05, 5'd1, 5'd3, 16'h0004), 1'b1, 32'h400);
        chk("R10 taken masked", 32'(br_taken), 0);
        clock_in();
        present({6'h3F, 26'd0}, 1'b1, 32'h404);
        chk("R10 halt masked", 32'(id_halt), 0);
        clock_in();
        present(itype(6'h23, 5'd5, 5'd6, 16'h0), 1'b1, 32'h408);
        clock_in();
        chk("R10 load bubble", 32'(x_bubble), 1);
        chk("R10 load flags", 32'({x_reg_we, x_mem_rd, x_mem_wr}), 0);
        present(rtype(5'd1, 5'd2, 5'd8, 6'h21), 1'b1, 32'h40C);
        clock_in();
        chk("R10 addu reg_we", 32'(x_reg_we), 0);
    endtask

    task automatic t_illegal();
        present(itype(6'h08, 5'd1, 5'd2, 16'h1), 1'b0, 32'h500);
        clock_in();
        chk("R11 bad opcode bubble", 32'(x_bubble), 1);
        chk("R11 bad opcode flags", 32'({x_reg_we, x_mem_rd, x_mem_wr}), 0);
        present(rtype(5'd1, 5'd2, 5'd8, 6'h20), 1'b0, 32'h504);
        chk("R11 bad funct no taken", 32'(br_taken), 0);
        clock_in();
        chk("R11 bad funct bubble", 32'(x_bubble), 1);
        chk("R11 bad funct reg_we", 32'(x_reg_we), 0);
    endtask

    task automatic t_regs();
        wr_reg(5'd0, 32'hDEAD_BEEF);
        present(rtype(5'd0, 5'd0, 5'd1, 6'h21), 1'b0, 32'h600);
        clock_in();
        chk("R6 r0 reads zero", x_rdata1, 32'd0);
        present(rtype(5'd0, 5'd1, 5'd1, 6'h21), 1'b0, 32'h604);
        wb_we = 1'b1; wb_addr = 5'd0; wb_data = 32'h5555_AAAA;
        clock_in();
        chk("R7 r0 not bypassed", x_rdata1, 32'd0);
        chk("R6 r1 stored", x_rdata2, 32'd5);
        present(rtype(5'd7, 5'd1, 5'd1, 6'h21), 1'b0, 32'h608);
        wb_we = 1'b1; wb_addr = 5'd7; wb_data = 32'hCAFE_F00D;
        #1;
        chk("R7 same-cycle bypass", x_rdata1, 32'd0);
        clock_in();
        chk("R7 bypass value", x_rdata1, 32'hCAFE_F00D);
        present(rtype(5'd1, 5'd7, 5'd1, 6'h21), 1'b0, 32'h60C);
        clock_in();
        chk("R6 r7 retained", x_rdata2, 32'hCAFE_F00D);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        wr_reg(5'd1, 32'd5);
        wr_reg(5'd2, 32'd5);
        wr_reg(5'd3, 32'd7);
        wr_reg(5'd4, 32'hFFFF_FFF0);
        wr_reg(5'd5, 32'h1234);
        t_rtype();
        t_load();
        t_store();
        t_branch();
        t_halt();
        t_bubble();
        t_illegal();
        t_regs();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule